// File: doc/BRIEF.md
# Stereo Audio Receive Holding Register

This block sits between a serial audio receiver's deserializer and a processor-side register bus. Each finished sample arrives as a one-cycle strobe carrying the data word and the index of the channel it came from. The block keeps exactly one sample in a holding register and shows that sample, with its channel index, on its read-data outputs. A ready flag tells software that a sample is waiting, and a read strobe consumes it.

If a sample arrives while the previous one has not been taken, the newer sample replaces it. The block then raises a sticky overrun flag and sets the bit for the arriving channel in a per-channel overrun field. Both stay set until a clear pulse.

In mono mode the block builds the right channel itself. When software reads a left-channel sample, a copy tagged as right channel is queued and delivered on the next cycle that has no receiver word. This copy obeys the same ready and overrun rules as a received word. Right-channel words from the receiver are dropped while mono mode is on.

Top module: `i2s_rx_holding`

## Requirements
- R1: With `mono_en` high, a read that takes a held word tagged LEFT_CH (0) queues a copy with the same data tagged RIGHT_CH (1). The copy arrives on the first cycle after the read in which `word_vld` is low.
- R2: A word arrival loads the holding register on that clock edge. After the edge `rx_ready` is 1, `rd_data` equals the word and `rd_ch` equals its channel.
- R3: A read (`rd_stb`) while `rx_ready` is 1 and no word arrives clears `rx_ready` on that edge. A read while `rx_ready` is 0 changes no output.
- R4: An arrival while `rx_ready` is 1 and `rd_stb` is low overwrites the held word, keeps `rx_ready` at 1 and sets `rx_ovr`.
- R5: On such an overrun, bit `ovr_ch[c]` is set, where c is the channel of the arriving word. The other bits are unchanged.
- R6: `rx_ovr` and `ovr_ch` hold their value until an `ovr_clr` pulse, which zeroes both. An overrun in the same cycle as `ovr_clr` wins.
- R7: A read and an arrival in the same cycle take the old word, load the new one, leave `rx_ready` at 1 and flag no overrun.
- R8: While `mono_en` is high, receiver words tagged RIGHT_CH are discarded: no load, no ready, no overrun. With `mono_en` low they are loaded normally.
- R9: After synchronous reset, `rx_ready`, `rx_ovr`, `ovr_ch`, `rd_data` and `rd_ch` are all zero and no copy is pending.
- R10: A mono copy that arrives while `rx_ready` is 1 and no read is made counts as an overrun on RIGHT_CH. It overwrites the held word, as in R4 and R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_vld | input | 1 | One-cycle strobe: a deserialized word is present |
| word_data | input | DATA_W | Deserialized sample |
| word_ch | input | CH_W | Channel index of the sample |
| rd_stb | input | 1 | Bus read of the holding register |
| mono_en | input | 1 | Receive mono mode |
| ovr_clr | input | 1 | Clears the sticky overrun status |
| rd_data | output | DATA_W | Held sample |
| rd_ch | output | CH_W | Channel index of the held sample |
| rx_ready | output | 1 | A sample is waiting |
| rx_ovr | output | 1 | Sticky overrun flag |
| ovr_ch | output | NUM_CH | Sticky per-channel overrun bits |

## Verification
A receiver word or read strobe that is present at a clock edge shows its effect on the holding register, the ready flag and the overrun status right after that same edge. A mono copy needs one more edge: it is queued at the read edge and loaded at the next edge that has no receiver word. The bench drives its inputs a short time after each rising edge. It samples reads at the falling edge before the edge that consumes the word. Every flag check is taken after the edge whose effect it verifies, so each expected value is tied to a known count of edges.

// File: rtl/i2s_rxh_pkg.sv
package i2s_rxh_pkg;

  typedef enum logic [1:0] {
    ARR_NONE = 2'd0,
    ARR_WIRE = 2'd1,
    ARR_DUP  = 2'd2
  } arr_src_e;

endpackage

// File: rtl/rxh_arrival.sv
module rxh_arrival
  import i2s_rxh_pkg::*;
#(
  parameter int DATA_W   = 24,
  parameter int CH_W     = 1,
  parameter int LEFT_CH  = 0,
  parameter int RIGHT_CH = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_vld,
  input  logic [DATA_W-1:0] word_data,
  input  logic [CH_W-1:0]   word_ch,
  input  logic              mono_en,
  input  logic              left_taken,
  input  logic [DATA_W-1:0] taken_data,
  output logic              arr_vld,
  output logic [DATA_W-1:0] arr_data,
  output logic [CH_W-1:0]   arr_ch,
  output arr_src_e          arr_src
);

  localparam logic [CH_W-1:0] RCH = CH_W'(RIGHT_CH);
  localparam logic [CH_W-1:0] LCH = CH_W'(LEFT_CH);

  logic              dup_pend;
  logic [DATA_W-1:0] dup_data;
  logic              wire_ok;

  // In mono mode the right slot is synthesized, so receiver right words are dropped.
  assign wire_ok = word_vld && !(mono_en && (word_ch == RCH));

  always_comb begin
    arr_src  = ARR_NONE;
    arr_data = '0;
    arr_ch   = LCH;
    if (wire_ok) begin
      arr_src  = ARR_WIRE;
      arr_data = word_data;
      arr_ch   = word_ch;
    end else if (dup_pend) begin
      arr_src  = ARR_DUP;
      arr_data = dup_data;
      arr_ch   = RCH;
    end
  end

  assign arr_vld = (arr_src != ARR_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      dup_pend <= 1'b0;
      dup_data <= '0;
    end else if (left_taken) begin
      dup_pend <= 1'b1;
      dup_data <= taken_data;
    end else if (arr_src == ARR_DUP) begin
      dup_pend <= 1'b0;
    end
  end

endmodule

// File: rtl/rxh_hold.sv
module rxh_hold #(
  parameter int DATA_W = 24,
  parameter int CH_W   = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arr_vld,
  input  logic [DATA_W-1:0] arr_data,
  input  logic [CH_W-1:0]   arr_ch,
  input  logic              rd_stb,
  output logic [DATA_W-1:0] hold_data,
  output logic [CH_W-1:0]   hold_ch,
  output logic              ready,
  output logic              rd_take,
  output logic              ovr_evt,
  output logic [CH_W-1:0]   ovr_evt_ch
);

  assign rd_take    = rd_stb && ready;
  assign ovr_evt    = arr_vld && ready && !rd_stb;
  assign ovr_evt_ch = arr_ch;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_data <= '0;
      hold_ch   <= '0;
      ready     <= 1'b0;
    end else begin
      if (arr_vld) begin
        hold_data <= arr_data;
        hold_ch   <= arr_ch;
        ready     <= 1'b1;
      end else if (rd_take) begin
        ready     <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/rxh_ovr_status.sv
module rxh_ovr_status #(
  parameter int NUM_CH = 2,
  parameter int CH_W   = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evt,
  input  logic [CH_W-1:0]   evt_ch,
  input  logic              clr,
  output logic              ovr,
  output logic [NUM_CH-1:0] ovr_bits
);

  always_ff @(posedge clk) begin
    if (rst)       ovr <= 1'b0;
    else if (evt)  ovr <= 1'b1;
    else if (clr)  ovr <= 1'b0;
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst)                                  ovr_bits[i] <= 1'b0;
      else if (evt && (evt_ch == CH_W'(i)))     ovr_bits[i] <= 1'b1;
      else if (clr)                             ovr_bits[i] <= 1'b0;
    end
  end

endmodule

// File: rtl/i2s_rx_holding.sv
module i2s_rx_holding
  import i2s_rxh_pkg::*;
#(
  parameter int DATA_W   = 24,
  parameter int NUM_CH   = 2,
  parameter int LEFT_CH  = 0,
  parameter int RIGHT_CH = 1,
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_vld,
  input  logic [DATA_W-1:0] word_data,
  input  logic [CH_W-1:0]   word_ch,
  input  logic              rd_stb,
  input  logic              mono_en,
  input  logic              ovr_clr,
  output logic [DATA_W-1:0] rd_data,
  output logic [CH_W-1:0]   rd_ch,
  output logic              rx_ready,
  output logic              rx_ovr,
  output logic [NUM_CH-1:0] ovr_ch
);

  logic              arr_vld;
  logic [DATA_W-1:0] arr_data;
  logic [CH_W-1:0]   arr_ch;
  arr_src_e          arr_src;
  logic              rd_take;
  logic              left_taken;
  logic              ovr_evt;
  logic [CH_W-1:0]   ovr_evt_ch;

  assign left_taken = rd_take && mono_en && (rd_ch == CH_W'(LEFT_CH));

  rxh_arrival #(
    .DATA_W  (DATA_W),
    .CH_W    (CH_W),
    .LEFT_CH (LEFT_CH),
    .RIGHT_CH(RIGHT_CH)
  ) u_arr (
    .clk       (clk),
    .rst       (rst),
    .word_vld  (word_vld),
    .word_data (word_data),
    .word_ch   (word_ch),
    .mono_en   (mono_en),
    .left_taken(left_taken),
    .taken_data(rd_data),
    .arr_vld   (arr_vld),
    .arr_data  (arr_data),
    .arr_ch    (arr_ch),
    .arr_src   (arr_src)
  );

  rxh_hold #(
    .DATA_W(DATA_W),
    .CH_W  (CH_W)
  ) u_hold (
    .clk       (clk),
    .rst       (rst),
    .arr_vld   (arr_vld),
    .arr_data  (arr_data),
    .arr_ch    (arr_ch),
    .rd_stb    (rd_stb),
    .hold_data (rd_data),
    .hold_ch   (rd_ch),
    .ready     (rx_ready),
    .rd_take   (rd_take),
    .ovr_evt   (ovr_evt),
    .ovr_evt_ch(ovr_evt_ch)
  );

  rxh_ovr_status #(
    .NUM_CH(NUM_CH),
    .CH_W  (CH_W)
  ) u_ovr (
    .clk     (clk),
    .rst     (rst),
    .evt     (ovr_evt),
    .evt_ch  (ovr_evt_ch),
    .clr     (ovr_clr),
    .ovr     (rx_ovr),
    .ovr_bits(ovr_ch)
  );

endmodule

// File: rtl/i2s_rx_holding_chk.sv
module i2s_rx_holding_chk
  import i2s_rxh_pkg::*;
#(
  parameter int DATA_W   = 24,
  parameter int NUM_CH   = 2,
  parameter int CH_W     = 1,
  parameter int LEFT_CH  = 0,
  parameter int RIGHT_CH = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              word_vld,
  input logic [CH_W-1:0]   word_ch,
  input logic              rd_stb,
  input logic              mono_en,
  input logic              ovr_clr,
  input logic              arr_vld,
  input logic [DATA_W-1:0] arr_data,
  input logic [CH_W-1:0]   arr_ch,
  input logic [DATA_W-1:0] rd_data,
  input logic [CH_W-1:0]   rd_ch,
  input logic              rx_ready,
  input logic              rx_ovr,
  input logic [NUM_CH-1:0] ovr_ch
);

  AST_MONO_COPY: assert property (@(posedge clk) disable iff (rst)
    (mono_en && rd_stb && rx_ready && rd_ch == CH_W'(LEFT_CH) && !arr_vld) ##1 !word_vld
      |=> rx_ready && rd_ch == CH_W'(RIGHT_CH) && rd_data == $past(rd_data, 2)); // R1

  AST_LOAD_SHOWS: assert property (@(posedge clk) disable iff (rst)
    arr_vld |=> rx_ready && rd_data == $past(arr_data) && rd_ch == $past(arr_ch)); // R2

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && rx_ready && !arr_vld) |=> !rx_ready); // R3

  AST_OVR_SETS: assert property (@(posedge clk) disable iff (rst)
    (arr_vld && rx_ready && !rd_stb) |=> rx_ovr && rx_ready); // R4

  AST_OVR_CH_BIT: assert property (@(posedge clk) disable iff (rst)
    (arr_vld && rx_ready && !rd_stb) |=> ovr_ch[$past(arr_ch)]); // R5

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (rx_ovr && !ovr_clr) |=> rx_ovr); // R6

  AST_CH_BITS_NEED_FLAG: assert property (@(posedge clk) disable iff (rst)
    (ovr_ch != '0) |-> rx_ovr); // R6

  AST_NO_OVR_ON_SWAP: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && rx_ready && arr_vld && !rx_ovr) |=> !rx_ovr && rx_ready); // R7

  AST_MONO_DROPS_RIGHT: assert property (@(posedge clk) disable iff (rst)
    (mono_en && word_vld && word_ch == CH_W'(RIGHT_CH) && !arr_vld && !rx_ready) |=> !rx_ready); // R8

endmodule

bind i2s_rx_holding i2s_rx_holding_chk #(
  .DATA_W  (DATA_W),
  .NUM_CH  (NUM_CH),
  .CH_W    (CH_W),
  .LEFT_CH (LEFT_CH),
  .RIGHT_CH(RIGHT_CH)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .word_vld(word_vld),
  .word_ch (word_ch),
  .rd_stb  (rd_stb),
  .mono_en (mono_en),
  .ovr_clr (ovr_clr),
  .arr_vld (arr_vld),
  .arr_data(arr_data),
  .arr_ch  (arr_ch),
  .rd_data (rd_data),
  .rd_ch   (rd_ch),
  .rx_ready(rx_ready),
  .rx_ovr  (rx_ovr),
  .ovr_ch  (ovr_ch)
);

// File: tb/i2s_rx_holding_tb.sv
module i2s_rx_holding_tb;

  localparam int CLK_P  = 10;
  localparam int DATA_W = 24;
  localparam int NUM_CH = 2;
  localparam int CH_W   = 1;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              word_vld = 1'b0;
  logic [DATA_W-1:0] word_data = '0;
  logic [CH_W-1:0]   word_ch = '0;
  logic              rd_stb = 1'b0;
  logic              mono_en = 1'b0;
  logic              ovr_clr = 1'b0;
  logic [DATA_W-1:0] rd_data;
  logic [CH_W-1:0]   rd_ch;
  logic              rx_ready;
  logic              rx_ovr;
  logic [NUM_CH-1:0] ovr_ch;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic [CH_W-1:0]   ch;
  } item_t;

  item_t exp_q[$];

  always #(CLK_P/2) clk = ~clk;

  i2s_rx_holding u_dut (
    .clk      (clk),
    .rst      (rst),
    .word_vld (word_vld),
    .word_data(word_data),
    .word_ch  (word_ch),
    .rd_stb   (rd_stb),
    .mono_en  (mono_en),
    .ovr_clr  (ovr_clr),
    .rd_data  (rd_data),
    .rd_ch    (rd_ch),
    .rx_ready (rx_ready),
    .rx_ovr   (rx_ovr),
    .ovr_ch   (ovr_ch)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drives one cycle of stimulus shortly after a rising edge.
  task automatic step(input bit vld, input logic [DATA_W-1:0] d, input logic [CH_W-1:0] c,
                      input bit rd, input bit clr);
    @(posedge clk);
    #2;
    word_vld  = vld;
    word_data = d;
    word_ch   = c;
    rd_stb    = rd;
    ovr_clr   = clr;
  endtask

  task automatic idle();
    step(1'b0, '0, '0, 1'b0, 1'b0);
  endtask

  task automatic send(input logic [DATA_W-1:0] d, input logic [CH_W-1:0] c);
    step(1'b1, d, c, 1'b0, 1'b0);
  endtask

  // Driver: records the word the bus read must return, then issues the read.
  task automatic read_exp(input logic [DATA_W-1:0] d, input logic [CH_W-1:0] c,
                          input bit vld, input logic [DATA_W-1:0] nd, input logic [CH_W-1:0] nc);
    exp_q.push_back('{data: d, ch: c});
    step(vld, nd, nc, 1'b1, 1'b0);
  endtask

  // Monitor: every consuming read is compared against the queue head.
  always @(negedge clk) begin
    if (!rst && rd_stb && rx_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3 unexpected read", 32'(rd_data), 32'hx);
      end else begin
        item_t e;
        e = exp_q.pop_front();
        chk(rd_data == e.data, "R2 read data", 32'(rd_data), 32'(e.data));
        chk(rd_ch == e.ch, "R2 read channel", 32'(rd_ch), 32'(e.ch));
      end
    end
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    idle();
    // R9 reset state
    chk(!rx_ready && !rx_ovr && ovr_ch == '0, "R9 flags", {rx_ready, rx_ovr, 30'(ovr_ch)}, 0);
    chk(rd_data == '0 && rd_ch == '0, "R9 data", 32'(rd_data), 0);

    // R2 load
    send(24'hA10001, 1'b0); idle();
    chk(rx_ready, "R2 ready", 32'(rx_ready), 1);
    chk(rd_data == 24'hA10001 && rd_ch == 1'b0, "R2 held", 32'(rd_data), 32'hA10001);

    // R3 read clears, read on empty does nothing
    read_exp(24'hA10001, 1'b0, 1'b0, '0, '0); idle();
    chk(!rx_ready, "R3 cleared", 32'(rx_ready), 0);
    step(1'b0, '0, '0, 1'b1, 1'b0); idle();
    chk(!rx_ready && !rx_ovr && rd_data == 24'hA10001, "R3 empty read", 32'(rd_data), 32'hA10001);

    // R4 R5 overrun
    send(24'hB10001, 1'b0); send(24'hB20002, 1'b1); idle();
    chk(rx_ready && rd_data == 24'hB20002 && rd_ch == 1'b1, "R4 overwrite", 32'(rd_data), 32'hB20002);
    chk(rx_ovr, "R4 flag", 32'(rx_ovr), 1);
    chk(ovr_ch == 2'b10, "R5 channel bit", 32'(ovr_ch), 2);

    // R6 sticky, clear, set wins over clear
    idle(); idle(); idle();
    chk(rx_ovr && ovr_ch == 2'b10, "R6 sticky", 32'(ovr_ch), 2);
    step(1'b0, '0, '0, 1'b0, 1'b1); idle();
    chk(!rx_ovr && ovr_ch == '0, "R6 cleared", {rx_ovr, 31'(ovr_ch)}, 0);
    step(1'b1, 24'hC10003, 1'b0, 1'b0, 1'b1); idle();
    chk(rx_ovr && ovr_ch == 2'b01, "R6 set wins", 32'(ovr_ch), 1);
    step(1'b0, '0, '0, 1'b0, 1'b1); idle();

    // R7 read and arrival together
    read_exp(24'hC10003, 1'b0, 1'b1, 24'hD10004, 1'b1); idle();
    chk(rx_ready && !rx_ovr && rd_data == 24'hD10004, "R7 swap", 32'(rd_data), 32'hD10004);
    read_exp(24'hD10004, 1'b1, 1'b0, '0, '0); idle();
    chk(!rx_ready, "R7 drained", 32'(rx_ready), 0);

    // R1 mono duplicate
    mono_en = 1'b1;
    send(24'hE10005, 1'b0); idle();
    read_exp(24'hE10005, 1'b0, 1'b0, '0, '0); idle(); idle();
    chk(rx_ready && rd_ch == 1'b1 && rd_data == 24'hE10005, "R1 copy", 32'(rd_data), 32'hE10005);
    chk(!rx_ovr, "R1 no overrun", 32'(rx_ovr), 0);
    read_exp(24'hE10005, 1'b1, 1'b0, '0, '0); idle(); idle();
    chk(!rx_ready, "R1 single copy", 32'(rx_ready), 0);

    // R8 right words dropped in mono
    send(24'hF10006, 1'b1); idle();
    chk(!rx_ready && !rx_ovr, "R8 dropped", 32'(rx_ready), 0);

    // R10 copy waits for the receiver word, then overruns on the right channel
    send(24'h610007, 1'b0); idle();
    read_exp(24'h610007, 1'b0, 1'b0, '0, '0);
    send(24'h620008, 1'b0); idle(); idle();
    chk(rx_ready && rd_ch == 1'b1 && rd_data == 24'h610007, "R10 copy held", 32'(rd_data), 32'h610007);
    chk(rx_ovr && ovr_ch == 2'b10, "R10 right overrun", 32'(ovr_ch), 2);
    read_exp(24'h610007, 1'b1, 1'b0, '0, '0); idle();
    step(1'b0, '0, '0, 1'b0, 1'b1); idle();

    // R8 contrast and mono off: no copy, right words accepted
    mono_en = 1'b0;
    send(24'h710009, 1'b0); idle();
    read_exp(24'h710009, 1'b0, 1'b0, '0, '0); idle(); idle();
    chk(!rx_ready, "R1 no copy when off", 32'(rx_ready), 0);
    send(24'h72000A, 1'b1); idle();
    chk(rx_ready && rd_ch == 1'b1 && rd_data == 24'h72000A, "R8 right kept", 32'(rd_data), 32'h72000A);
    read_exp(24'h72000A, 1'b1, 1'b0, '0, '0); idle();

    chk(exp_q.size() == 0, "R2 all reads seen", 32'(exp_q.size()), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule